// File: doc/BRIEF.md
# RC5 Infrared Frame Receiver

This block receives RC5 remote-control frames from the demodulated output of an infrared receiver. It expects that signal to have already passed through a two-flop synchroniser. The line idles high. A frame holds fourteen bits, most significant first: two start bits, a toggle bit, a 5-bit address and a 6-bit command. Each bit is a biphase pair of half-bit levels. The block does not decode Manchester edges. It treats the falling edge in the middle of the first start bit like the start bit of a UART. It confirms that edge with one level check in the first half of the second start bit. From there it counts fixed intervals to sampling points that fall three quarters of the way into each later bit.

The controller is a four-state machine:

- **IDLE**: waits for a falling edge. On an edge it moves to CONFIRM (transition *start*).
- **CONFIRM**: counts the confirmation delay. If the line is high at the check point, it records the first start bit as a 1 and moves to SAMPLE (*confirm*). If the line is low, it returns to IDLE (*reject*).
- **SAMPLE**: samples the line once per interval and shifts in the inverted level. After the first sample it waits one bit period between samples (*next*). When the fourteenth bit is in, it moves to HOLD (*complete*) and strobes `frame_valid`.
- **HOLD**: keeps the word and ignores the line until `rearm` is pulsed (*rearm*, back to IDLE).

All intervals are parameters counted in clock cycles. The defaults assume an 8 MHz clock: 1778 us per bit, a check 1352 us after the edge, and a first sample 871 us after the check.

Top module: `rc5_frame_receiver`

## Requirements
- R1: After reset, `frame_valid`, `frame_pending`, `frame_word`, `toggle`, `address` and `command` are all zero.
- R2: In IDLE, let e be the first clock edge at which `rx_line` is low after being high. The line is checked at edge e+CONFIRM_CYC. If the line is low there, the start is rejected. No frame is reported, and the receiver is idle again and will accept the next falling edge.
- R3: If the check finds the line high, samples are taken at edges e+CONFIRM_CYC+FIRST_CYC+k·BIT_CYC for k = 0..12. Each sample records the inverse of `rx_line`: a low line gives 1 and a high line gives 0.
- R4: `frame_word[13]` is 1 for the confirmed first start bit. The thirteen samples then fill bits 12 down to 0 in the order they are taken.
- R5: `toggle` is `frame_word[11]`, `address` is `frame_word[10:6]` and `command` is `frame_word[5:0]`.
- R6: After the thirteenth sample, `frame_valid` is high for exactly one cycle: the cycle that follows that sampling edge. `frame_pending` goes high in that same cycle and stays high.
- R7: While `frame_pending` is high, falling edges are ignored. No strobe follows, and `frame_word` keeps its value.
- R8: A `rearm` pulse while pending clears `frame_pending` on the next cycle. A `rearm` pulse in any other state has no effect, so a reception in progress completes unchanged.
- R9: Suppose `rearm` and a falling edge meet on the same edge while the receiver is pending. The rearm takes effect and the edge is not taken. The receiver ends up idle and does not report that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_line | input | 1 | Synchronised demodulated line, idles high |
| rearm | input | 1 | Releases a held frame and returns the receiver to IDLE |
| frame_valid | output | 1 | One-cycle strobe when a frame is complete |
| frame_pending | output | 1 | High while a received frame is held |
| frame_word | output | 14 | Assembled frame, first bit in bit 13 |
| toggle | output | 1 | Toggle field |
| address | output | 5 | Address field |
| command | output | 6 | Command field |

## Verification
The two functions that can meet on one edge are the release of a held frame by `rearm` and the detection of a new falling edge. The bench provokes this by driving `rearm` high on the very edge where the line first goes low. It follows that edge with a waveform that a receiver taking the edge would confirm and then decode into a frame of zeros. The case is judged at the ports: no `frame_valid` may appear for that waveform, and `frame_pending` must be low afterwards. A complete sweep of all 64 command codes, with varied address and toggle bits, fixes the exact strobe cycle and the field positions.

// File: rtl/rc5rx_pkg.sv
package rc5rx_pkg;
    localparam int FRAME_BITS = 14;
    localparam int ADDR_BITS  = 5;
    localparam int CMD_BITS   = 6;
    localparam int TOG_POS    = CMD_BITS + ADDR_BITS;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_SAMPLE  = 2'd2,
        ST_HOLD    = 2'd3
    } rx_state_t;
endpackage

// File: rtl/rc5_fall_detect.sv
module rc5_fall_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= line;
    end

    assign fall = prev_q & ~line;
endmodule

// File: rtl/rc5_interval_timer.sv
module rc5_interval_timer #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/rc5_bit_shifter.sv
module rc5_bit_shifter #(
    parameter int N = 14,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          init,
    input  logic          shift,
    input  logic          clear,
    input  logic          din,
    output logic [N-1:0]  word,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word  <= '0;
            count <= '0;
        end else if (init) begin
            word  <= {{(N-1){1'b0}}, 1'b1};
            count <= CW'(1);
        end else if (shift) begin
            word  <= {word[N-2:0], din};
            count <= count + 1'b1;
        end else if (clear) begin
            count <= '0;
        end
    end

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(N));

    assert_shift_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !init) |=> (word[0] == $past(din)));
endmodule

// File: rtl/rc5_frame_receiver.sv
module rc5_frame_receiver
    import rc5rx_pkg::*;
#(
    parameter int BIT_CYC     = 14224,
    parameter int CONFIRM_CYC = 10816,
    parameter int FIRST_CYC   = 6968
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_line,
    input  logic                  rearm,
    output logic                  frame_valid,
    output logic                  frame_pending,
    output logic [FRAME_BITS-1:0] frame_word,
    output logic                  toggle,
    output logic [ADDR_BITS-1:0]  address,
    output logic [CMD_BITS-1:0]   command
);
    localparam int MAX_AB = (BIT_CYC > CONFIRM_CYC) ? BIT_CYC : CONFIRM_CYC;
    localparam int MAX_C  = (MAX_AB > FIRST_CYC) ? MAX_AB : FIRST_CYC;
    localparam int CNT_W  = $clog2(MAX_C + 1);
    localparam int BC_W   = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] LD_CONFIRM = CNT_W'(CONFIRM_CYC - 1);
    localparam logic [CNT_W-1:0] LD_FIRST   = CNT_W'(FIRST_CYC - 1);
    localparam logic [CNT_W-1:0] LD_BIT     = CNT_W'(BIT_CYC - 1);
    localparam logic [BC_W-1:0]  LAST_IDX   = BC_W'(FRAME_BITS - 1);

    rx_state_t        state_q, state_d;
    logic             fall;
    logic             tmr_load, tmr_expired;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_init, sh_shift, sh_clear;
    logic [BC_W-1:0]  bit_count;
    logic             done;
    logic             valid_q;

    rc5_fall_detect u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .line  (rx_line),
        .fall  (fall)
    );

    rc5_interval_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    rc5_bit_shifter #(.N(FRAME_BITS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (sh_init),
        .shift (sh_shift),
        .clear (sh_clear),
        .din   (~rx_line),
        .word  (frame_word),
        .count (bit_count)
    );

    // Next state and datapath control
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = LD_BIT;
        sh_init  = 1'b0;
        sh_shift = 1'b0;
        sh_clear = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (fall) begin
                    state_d  = ST_CONFIRM;
                    tmr_load = 1'b1;
                    tmr_val  = LD_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (tmr_expired) begin
                    if (rx_line) begin
                        state_d  = ST_SAMPLE;
                        tmr_load = 1'b1;
                        tmr_val  = LD_FIRST;
                        sh_init  = 1'b1;
                    end else begin
                        state_d  = ST_IDLE;
                    end
                end
            end
            ST_SAMPLE: begin
                if (tmr_expired) begin
                    sh_shift = 1'b1;
                    if (bit_count == LAST_IDX) begin
                        state_d = ST_HOLD;
                        done    = 1'b1;
                    end else begin
                        tmr_load = 1'b1;
                        tmr_val  = LD_BIT;
                    end
                end
            end
            ST_HOLD: begin
                if (rearm) begin
                    state_d  = ST_IDLE;
                    sh_clear = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            valid_q <= 1'b0;
        end else begin
            state_q <= state_d;
            valid_q <= done;
        end
    end

    // Outputs
    always_comb begin
        frame_valid   = valid_q;
        frame_pending = (state_q == ST_HOLD);
        toggle        = frame_word[TOG_POS];
        address       = frame_word[TOG_POS-1:CMD_BITS];
        command       = frame_word[CMD_BITS-1:0];
    end

    assert_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIRM && tmr_expired && !rx_line) |=> (state_q == ST_IDLE && !frame_valid));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    assert_valid_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (frame_pending && bit_count == BC_W'(FRAME_BITS)));

    assert_hold_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pending && !rearm) |=> (frame_pending && $stable(frame_word)));

    assert_rearm_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pending && rearm) |=> (!frame_pending && state_q == ST_IDLE));
endmodule

// File: tb/sim_rc5_frame_receiver.sv
module sim_rc5_frame_receiver;
    localparam int CLK_PERIOD = 10;
    localparam int BIT        = 16;
    localparam int CONF       = 12;
    localparam int FIRST      = 8;
    localparam int WAVE_LEN   = 248;
    localparam int EXP_T      = BIT/2 + CONF + FIRST + 12*BIT + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_line = 1'b1;
    logic        rearm = 1'b0;
    logic        frame_valid, frame_pending, toggle;
    logic [13:0] frame_word;
    logic [4:0]  address;
    logic [5:0]  command;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rc5_frame_receiver #(.BIT_CYC(BIT), .CONFIRM_CYC(CONF), .FIRST_CYC(FIRST)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .rearm(rearm),
        .frame_valid(frame_valid), .frame_pending(frame_pending),
        .frame_word(frame_word), .toggle(toggle), .address(address), .command(command)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // mode 0: biphase frame, 1: long low (rejected start), 2: short low pulse then high
    function automatic logic level(input int mode, input logic [13:0] w, input int t);
        int k;
        logic d;
        if (mode == 1) return !(t >= BIT/2 && t < 40);
        if (mode == 2) return !(t >= BIT/2 && t < BIT);
        if (t >= 14*BIT) return 1'b1;
        k = t / BIT;
        d = w[13-k];
        return ((t % BIT) >= BIT/2) ? ~d : d;
    endfunction

    task automatic run_wave(input int mode, input logic [13:0] w, input int rearm_t,
                            output int first_t, output int nvalid);
        first_t = -1;
        nvalid  = 0;
        for (int t = 0; t < WAVE_LEN; t++) begin
            @(negedge clk);
            if (frame_valid) begin
                nvalid++;
                if (first_t < 0) first_t = t;
            end
            rx_line = level(mode, w, t);
            rearm   = (t == rearm_t);
        end
        @(negedge clk);
        rearm = 1'b0;
        if (frame_valid) nvalid++;
    endtask

    task automatic pulse_rearm();
        @(negedge clk);
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
        check(frame_pending == 1'b0, "R8", "pending after rearm", frame_pending, 0);
    endtask

    task automatic check_frame(input logic [13:0] w, input int first_t, input int nvalid,
                               input string req);
        check(nvalid == 1, "R6", "strobe count", nvalid, 1);
        check(first_t == EXP_T, "R6", "strobe cycle", first_t, EXP_T);
        check(frame_word == w, req, "frame word", frame_word, w);
        check(toggle == w[11], "R5", "toggle", toggle, w[11]);
        check(address == w[10:6], "R5", "address", address, w[10:6]);
        check(command == w[5:0], "R5", "command", command, w[5:0]);
        check(frame_pending == 1'b1, "R6", "pending held", frame_pending, 1);
    endtask

    initial begin
        int ft, nv;
        logic [13:0] w, held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(frame_valid == 0, "R1", "valid at reset", frame_valid, 0);
        check(frame_pending == 0, "R1", "pending at reset", frame_pending, 0);
        check(frame_word == 0, "R1", "word at reset", frame_word, 0);
        check({toggle, address, command} == 0, "R1", "fields at reset",
              {toggle, address, command}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Sweep of all command codes (R3 R4 R5 R6)
        for (int c = 0; c < 64; c++) begin
            logic [4:0] a;
            a = 5'((c * 7) ^ (c >> 1));
            w = {2'b11, c[0] ^ c[3], a, 6'(c)};
            run_wave(0, w, -1, ft, nv);
            check_frame(w, ft, nv, "R4");
            pulse_rearm();
        end

        // R3 level inversion extremes
        run_wave(0, 14'h3000, -1, ft, nv);
        check_frame(14'h3000, ft, nv, "R3");
        pulse_rearm();
        run_wave(0, 14'h3FFF, -1, ft, nv);
        check_frame(14'h3FFF, ft, nv, "R3");
        pulse_rearm();

        // R2 rejected start, then a good frame is still received
        run_wave(1, 14'h0, -1, ft, nv);
        check(nv == 0, "R2", "no strobe on rejected start", nv, 0);
        check(frame_pending == 0, "R2", "idle after reject", frame_pending, 0);
        run_wave(0, 14'h3155, -1, ft, nv);
        check_frame(14'h3155, ft, nv, "R2");

        // R7 edges ignored while pending
        held = frame_word;
        run_wave(0, 14'h3ABC, -1, ft, nv);
        check(nv == 0, "R7", "no strobe while pending", nv, 0);
        check(frame_word == held, "R7", "word kept while pending", frame_word, held);
        check(frame_pending == 1, "R7", "still pending", frame_pending, 1);

        // R9 rearm meets falling edge: the edge is not taken
        run_wave(2, 14'h0, BIT/2, ft, nv);
        check(nv == 0, "R9", "edge with rearm not taken", nv, 0);
        check(frame_pending == 0, "R9", "idle after rearm", frame_pending, 0);

        // R8 rearm during reception has no effect
        run_wave(0, 14'h32A9, 100, ft, nv);
        check_frame(14'h32A9, ft, nv, "R8");
        pulse_rearm();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1;
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule